// File: doc/BRIEF.md
# Edge-Serviced Watchdog with Boot Grace Window

This block supervises a processor through a single service line. Software must make the line change level, either up or down, often enough. If the line sits at one level for longer than a programmable number of clock cycles, the block raises a one-cycle timeout request toward the chip's reset controller.

Boot code needs time before it can start servicing the line. For that reason, the block applies a much longer startup window from the moment reset is released until the first level change is seen. After that first change, the short run window applies until the next reset.

After a timeout the block freezes. It stays silent until reset has been asserted and released again. A separate input reports that the service pin is left unconnected. While that input is high, the watchdog is switched off and its count is held at zero. Both windows are parameters counted in clock cycles. The service line passes through a synchronizer before edge detection.

Top module: `edge_watchdog`

## Requirements
- R1: While `rst_n` is low, `timeout_req` is 0 and the count is cleared. After release, timing starts again from zero in the startup window.
- R2: A change of `wdi` in either direction, low-to-high or high-to-low, restarts the count, so changes spaced closer than the active window never cause a timeout.
- R3: If no change is detected after release, `timeout_req` goes high immediately after the STARTUP_CYC-th rising clock edge that follows the release.
- R4: The first detected change switches the block to the run window until the next reset. A `wdi` change set up before clock edge P0 is detected at edge P0+SYNC_STAGES. Without a further change, `timeout_req` goes high after edge P0+SYNC_STAGES+TIMEOUT_CYC.
- R5: `timeout_req` is high for exactly one clock cycle per timeout.
- R6: While `pin_float` is high, no timeout is raised, the count is held at zero, and `wdi` changes are ignored, so the window in use does not change. When `pin_float` falls, counting restarts from zero in the window that was in use.
- R7: After a timeout, no further timeout is raised, whatever `wdi` does, until reset is asserted and released again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Shared reset state, active low, asynchronous assertion; the timer is held cleared while low |
| pin_float | input | 1 | High when the service pin is detected as unconnected; disables the watchdog |
| wdi | input | 1 | Asynchronous service line from the processor |
| timeout_req | output | 1 | One-cycle timeout request to the reset controller |

## Verification
The following properties are checked on every cycle:
- the one-cycle pulse width;
- silence while the pin is floating;
- a restart of the count after a detected change;
- the run window staying in force once entered;
- the frozen state after a timeout holding until reset;
- the count never passing the active window's last value;
- silence during reset.

Some behaviour can only be shown by the bench's scenarios. These are:
- the exact edge on which the pulse appears after release and after a `wdi` change, including the synchronizer latency;
- the startup window staying in force across a floating interval;
- long runs of random service gaps that straddle the run window.

// File: rtl/edge_watchdog_pkg.sv
package edge_watchdog_pkg;

  typedef enum logic [1:0] {
    WD_BOOT = 2'd0,
    WD_RUN  = 2'd1,
    WD_DONE = 2'd2
  } wd_mode_e;

  // Window length (in quiet cycles) that applies in a given mode.
  function automatic int unsigned wd_window(wd_mode_e m, int unsigned boot_cyc,
                                            int unsigned run_cyc);
    return (m == WD_BOOT) ? boot_cyc : run_cyc;
  endfunction

  function automatic int unsigned wd_max(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wd_sync.sv
module wd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st;

  // Free-running: the chain keeps sampling during reset so it is settled at release.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) st[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/wd_edge.sv
module wd_edge (
  input  logic clk,
  input  logic lvl,
  output logic toggled
);
  logic lvl_prev;

  always_ff @(posedge clk) lvl_prev <= lvl;

  assign toggled = lvl ^ lvl_prev;
endmodule

// File: rtl/wd_core.sv
module wd_core
  import edge_watchdog_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 54000,
  parameter int unsigned TIMEOUT_CYC = 1600,
  parameter int unsigned CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_float,
  input  logic             edge_in,
  output logic [CNT_W-1:0] cnt,
  output wd_mode_e         mode,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt_q;
  wd_mode_e         mode_q;
  logic             pulse_q;
  logic [CNT_W-1:0] last_cnt;

  function automatic logic [CNT_W-1:0] final_count(wd_mode_e m);
    return CNT_W'(wd_window(m, STARTUP_CYC, TIMEOUT_CYC) - 1);
  endfunction

  assign last_cnt = final_count(mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      mode_q  <= WD_BOOT;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (pin_float) begin
        cnt_q <= '0;
      end else if (mode_q == WD_DONE) begin
        cnt_q <= '0;
      end else if (edge_in) begin
        cnt_q  <= '0;
        mode_q <= WD_RUN;
      end else if (cnt_q == last_cnt) begin
        cnt_q   <= '0;
        mode_q  <= WD_DONE;
        pulse_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt   = cnt_q;
  assign mode  = mode_q;
  assign pulse = pulse_q;
endmodule

// File: rtl/edge_watchdog.sv
module edge_watchdog
  import edge_watchdog_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STARTUP_CYC = 54000,
  parameter int unsigned TIMEOUT_CYC = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_float,
  input  logic wdi,
  output logic timeout_req
);
  localparam int unsigned LONGEST = wd_max(STARTUP_CYC, TIMEOUT_CYC);
  localparam int unsigned CNT_W   = $clog2(LONGEST + 1);

  // Named internal events, brought out for the bound checker.
  logic             wdi_sync;
  logic             edge_seen;
  logic [CNT_W-1:0] quiet_cnt;
  wd_mode_e         wd_mode;

  wd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (wdi),
    .q   (wdi_sync)
  );

  wd_edge u_edge (
    .clk     (clk),
    .lvl     (wdi_sync),
    .toggled (edge_seen)
  );

  wd_core #(
    .STARTUP_CYC (STARTUP_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CNT_W       (CNT_W)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_float (pin_float),
    .edge_in   (edge_seen),
    .cnt       (quiet_cnt),
    .mode      (wd_mode),
    .pulse     (timeout_req)
  );
endmodule

// File: rtl/edge_watchdog_chk.sv
module edge_watchdog_chk
  import edge_watchdog_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 54000,
  parameter int unsigned TIMEOUT_CYC = 1600,
  parameter int unsigned CNT_W       = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pin_float,
  input logic             timeout_req,
  input logic             edge_seen,
  input logic [CNT_W-1:0] quiet_cnt,
  input wd_mode_e         wd_mode
);
  logic [CNT_W-1:0] top_cnt;
  assign top_cnt = CNT_W'(wd_window(wd_mode, STARTUP_CYC, TIMEOUT_CYC) - 1);

  AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (rst_n)
    !timeout_req); // R1

  AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && !pin_float && wd_mode != WD_DONE) |=> (quiet_cnt == '0)); // R2

  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_cnt <= top_cnt); // R3

  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_mode == WD_RUN) |=> (wd_mode != WD_BOOT)); // R4

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_req |=> !timeout_req); // R5

  AST_FLOAT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    pin_float |=> (!timeout_req && quiet_cnt == '0)); // R6

  AST_PULSE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_req |-> (wd_mode == WD_DONE)); // R7

  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_mode == WD_DONE) |=> (wd_mode == WD_DONE && !timeout_req)); // R7
endmodule

bind edge_watchdog edge_watchdog_chk #(
  .STARTUP_CYC (STARTUP_CYC),
  .TIMEOUT_CYC (TIMEOUT_CYC),
  .CNT_W       (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_float   (pin_float),
  .timeout_req (timeout_req),
  .edge_seen   (edge_seen),
  .quiet_cnt   (quiet_cnt),
  .wd_mode     (wd_mode)
);

// File: tb/edge_watchdog_bench.sv
module edge_watchdog_bench;
  localparam int SYNC = 2;
  localparam int SU   = 150;
  localparam int TO   = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic pin_float = 1'b0;
  logic wdi = 1'b0;
  logic timeout_req;

  int checks = 0;
  int errors = 0;
  int idx = 0;
  int last_pulse = -1;
  int pulse_cnt = 0;

  // Bench-side expectation state.
  logic m_sync [SYNC];
  logic m_prev = 1'b0;
  int   m_cnt = 0;
  bit   m_run = 0;
  bit   m_done = 0;

  always #5 clk = ~clk;

  edge_watchdog #(
    .SYNC_STAGES (SYNC),
    .STARTUP_CYC (SU),
    .TIMEOUT_CYC (TO)
  ) u_edge_watchdog (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_float   (pin_float),
    .wdi         (wdi),
    .timeout_req (timeout_req)
  );

  function automatic int window(bit run);
    return run ? TO : SU;
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic check(input string tag, input int got, input int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, expv);
    end
  endtask

  task automatic tick(input string tag);
    logic ed;
    logic expv;
    @(posedge clk);
    ed = m_sync[SYNC-1] ^ m_prev;
    m_prev = m_sync[SYNC-1];
    for (int i = SYNC - 1; i > 0; i--) m_sync[i] = m_sync[i-1];
    m_sync[0] = wdi;
    expv = 1'b0;
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_done = 0;
    end else if (pin_float) begin
      m_cnt = 0;
    end else if (m_done) begin
      m_cnt = 0;
    end else if (ed) begin
      m_cnt = 0; m_run = 1;
    end else if (m_cnt == window(m_run) - 1) begin
      expv = 1'b1; m_done = 1; m_cnt = 0;
    end else begin
      m_cnt++;
    end
    idx++;
    @(negedge clk);
    checks++;
    if (timeout_req !== expv) begin
      errors++;
      $display("FAIL %s cycle %0d timeout_req got %0b expected %0b", tag, idx, timeout_req, expv);
    end
    if (timeout_req === 1'b1) begin
      last_pulse = idx;
      pulse_cnt++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (6) begin
      wdi = ~wdi;
      tick("R1");
    end
    repeat (SYNC + 2) tick("R1");
    check("R1 reset output", int'(timeout_req), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int base;
    int p0;
    for (int i = 0; i < SYNC; i++) m_sync[i] = 1'b0;
    void'($urandom(32'd20240611));
    #2 rst_n = 1'b0;

    // R3 / R5 / R7: no service after release.
    do_reset();
    rst_n = 1'b1;
    base = idx; last_pulse = -1; pulse_cnt = 0;
    repeat (SU + 5) tick("R3");
    check("R3 startup pulse cycle", last_pulse, base + SU);
    check("R5 pulse count", pulse_cnt, 1);
    repeat (3 * TO) begin
      wdi = ~wdi;
      tick("R7");
    end
    repeat (2 * TO) tick("R7");
    check("R7 frozen after timeout", pulse_cnt, 1);

    // R1: reset re-arms; R4: run window after first change.
    do_reset();
    rst_n = 1'b1;
    last_pulse = -1; pulse_cnt = 0;
    repeat (10) tick("R4");
    wdi = ~wdi;
    tick("R4");
    p0 = idx;
    repeat (SYNC + TO + 5) tick("R4");
    check("R4 run window pulse cycle", last_pulse, p0 + SYNC + TO);
    check("R5 run pulse count", pulse_cnt, 1);

    // R2: both polarities service the timer.
    do_reset();
    rst_n = 1'b1;
    last_pulse = -1;
    repeat (40) begin
      repeat (TO - 4) tick("R2");
      wdi = ~wdi;
      tick("R2");
    end
    check("R2 no timeout while serviced", last_pulse, -1);

    // R6: floating pin disables, window unchanged.
    do_reset();
    pin_float = 1'b1;
    rst_n = 1'b1;
    last_pulse = -1;
    for (int k = 0; k < SU + 40; k++) begin
      if (k % 7 == 0 && k < SU + 20) wdi = ~wdi;
      tick("R6");
    end
    check("R6 silent while floating", last_pulse, -1);
    pin_float = 1'b0;
    base = idx;
    repeat (SU + 5) tick("R6");
    check("R6 boot window after float", last_pulse, base + SU);

    // Random service gaps around the run window, with occasional floating.
    for (int r = 0; r < 6; r++) begin
      do_reset();
      rst_n = 1'b1;
      repeat (30) begin
        int gap;
        gap = int'($urandom_range(TO + 8, 1));
        pin_float = ($urandom_range(7, 0) == 0);
        repeat (gap) tick("R4 random");
        wdi = ~wdi;
        tick("R2 random");
      end
      pin_float = 1'b0;
    end

    summary();
    $finish;
  end
endmodule